// File: doc/BRIEF.md
# Hot-Plug Status Poll Scheduler

This block decides what a hot-plug controller poller does on each wake-up. Most passes are cheap: it reads one byte in which each bit reports a slot's mechanical latch. It then compares that byte with the value it stored last time and asks for a status reread of every slot whose latch bit changed. After a fixed number of such passes it runs a full pass instead. In a full pass it raises a single scan-all request and then reads the latch byte again, so that the stored copy is current. That read produces no reread requests.

Every pass ends in a sleep measured in timebase ticks. At the end of the sleep the block chooses between a latch pass and a full pass from a pass counter. If a stop request is present at that moment, it halts instead. The bus transfers behind each request and the meaning of the status bytes belong to neighbouring logic. That logic answers the latch-read strobe with a valid byte and accepts scan-all and per-slot reread requests through valid/ready handshakes.

Top module: `hp_poll_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `latch_rd` is 1 and `scan_all_valid` and `slot_valid` are 0. The stored latch byte resets to 0x00, so the first latch pass compares against zero.
- R2: `latch_rd` stays at 1 until the cycle in which `latch_vld` is 1. In that cycle `latch_data` is captured.
- R3: In a latch pass, each bit position from FIRST_SLOT (default 1) to LAST_SLOT (default 6) that differs between the stored and new byte produces exactly one reread request, with `slot_id` equal to the bit position. The requests come in ascending order. Bit 0 and bits above LAST_SLOT never produce a request.
- R4: While `slot_valid` is 1 and `slot_ready` is 0, `slot_valid` and `slot_id` hold. A request is consumed in a cycle with both at 1.
- R5: A latch pass whose masked difference is zero raises no reread request and goes straight to sleep.
- R6: After each pass, no request is raised until SLEEP_TICKS (default 4) `tick` pulses have been seen. The next request appears in the cycle after the last of these pulses.
- R7: A pass counter, reset to 0, counts every completed pass. At a wake-up where it equals FULL_RATIO (default 5), it clears and a full pass runs; otherwise a latch pass runs. So the first full pass follows five latch passes, and each later one follows four.
- R8: A full pass holds `scan_all_valid` until `scan_all_ready`, then raises `latch_rd`. The byte returned is stored but raises no reread request.
- R9: If `stop` is 1 in the cycle of the final sleep tick, no further request is ever raised until reset. A `stop` that drops before that tick has no effect.
- R10: At most one of `latch_rd`, `scan_all_valid` and `slot_valid` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse used to measure sleep |
| stop | input | 1 | Halt request, sampled at the final sleep tick |
| latch_rd | output | 1 | Request to read the latch byte |
| latch_vld | input | 1 | Latch byte on `latch_data` is valid |
| latch_data | input | LATCH_W | Latch byte, one bit per slot |
| scan_all_valid | output | 1 | Full status scan request |
| scan_all_ready | input | 1 | Full scan request accepted |
| slot_valid | output | 1 | Single-slot reread request |
| slot_ready | input | 1 | Single-slot reread accepted |
| slot_id | output | clog2(LATCH_W) | Slot number for the reread request |

## Verification
The hardest state to reach is the second full pass. Getting there takes a full pass followed by four more latch passes, each with a complete sleep of ticks in between. Only that path shows that the counter restarts at one rather than zero and that the byte stored by the full pass becomes the next comparison base. A table of twelve passes covers this. Each entry gives the pass kind expected at wake-up, the latch byte to return and the set of slots expected to be reread. Each pass is followed by an exact count of tick pulses, so the wake cycle, the pass ratio and the latch history are all checked along one long path.

// File: rtl/hp_poll_pkg.sv
package hp_poll_pkg;

  typedef enum logic [2:0] {
    ST_LATCH_RD  = 3'd0,  // waiting for the latch byte of a latch pass
    ST_LATCH_DIF = 3'd1,  // issuing per-slot rereads
    ST_SCAN_ALL  = 3'd2,  // full scan request outstanding
    ST_FULL_RD   = 3'd3,  // latch refresh after the full scan
    ST_SLEEP     = 3'd4,  // counting ticks
    ST_HALT      = 3'd5   // polling stopped
  } poll_state_t;

endpackage

// File: rtl/hp_sleep_timer.sv
module hp_sleep_timer #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expire
);

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/hp_slot_picker.sv
module hp_slot_picker #(
  parameter int W = 8
) (
  input  logic [W-1:0]         pend,
  output logic                 any,
  output logic [$clog2(W)-1:0] idx,
  output logic [W-1:0]         lowest
);

  localparam int IW = $clog2(W);

  assign any    = |pend;
  assign lowest = pend & (~pend + 1'b1);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/hp_poll_sched.sv
module hp_poll_sched #(
  parameter int LATCH_W     = 8,
  parameter int FIRST_SLOT  = 1,
  parameter int LAST_SLOT   = 6,
  parameter int SLEEP_TICKS = 4,
  parameter int FULL_RATIO  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       stop,
  output logic                       latch_rd,
  input  logic                       latch_vld,
  input  logic [LATCH_W-1:0]         latch_data,
  output logic                       scan_all_valid,
  input  logic                       scan_all_ready,
  output logic                       slot_valid,
  input  logic                       slot_ready,
  output logic [$clog2(LATCH_W)-1:0] slot_id
);

  import hp_poll_pkg::*;

  localparam int IDW   = $clog2(LATCH_W);
  localparam int CNT_W = $clog2(FULL_RATIO + 1);
  localparam logic [CNT_W-1:0] RATIO_V = CNT_W'(FULL_RATIO);

  // slot range mask, reserved bit 0 and bits outside the range cleared
  logic [LATCH_W-1:0] range_mask;
  for (genvar g = 0; g < LATCH_W; g++) begin : g_mask
    assign range_mask[g] = (g >= FIRST_SLOT) && (g <= LAST_SLOT) && (g != 0);
  end

  poll_state_t        st_q;
  logic [LATCH_W-1:0] latch_q;
  logic [LATCH_W-1:0] pend_q;
  logic [CNT_W-1:0]   pass_q;

  logic               wake;
  logic               pick_any;
  logic [IDW-1:0]     pick_idx;
  logic [LATCH_W-1:0] pick_low;

  hp_sleep_timer #(.TICKS(SLEEP_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (st_q == ST_SLEEP),
    .tick   (tick),
    .expire (wake)
  );

  hp_slot_picker #(.W(LATCH_W)) u_pick (
    .pend   (pend_q),
    .any    (pick_any),
    .idx    (pick_idx),
    .lowest (pick_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_LATCH_RD;
      latch_q <= '0;
      pend_q  <= '0;
      pass_q  <= '0;
    end else begin
      unique case (st_q)
        ST_LATCH_RD: begin
          if (latch_vld) begin
            pend_q  <= (latch_q ^ latch_data) & range_mask;
            latch_q <= latch_data;
            st_q    <= ST_LATCH_DIF;
          end
        end
        ST_LATCH_DIF: begin
          if (!pick_any) begin
            pass_q <= pass_q + 1'b1;
            st_q   <= ST_SLEEP;
          end else if (slot_ready) begin
            pend_q <= pend_q & ~pick_low;
          end
        end
        ST_SCAN_ALL: begin
          if (scan_all_ready) st_q <= ST_FULL_RD;
        end
        ST_FULL_RD: begin
          if (latch_vld) begin
            latch_q <= latch_data;
            pass_q  <= pass_q + 1'b1;
            st_q    <= ST_SLEEP;
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            if (stop) begin
              st_q <= ST_HALT;
            end else if (pass_q == RATIO_V) begin
              pass_q <= '0;
              st_q   <= ST_SCAN_ALL;
            end else begin
              st_q <= ST_LATCH_RD;
            end
          end
        end
        ST_HALT: st_q <= ST_HALT;
        default: st_q <= ST_LATCH_RD;
      endcase
    end
  end

  assign latch_rd       = (st_q == ST_LATCH_RD) || (st_q == ST_FULL_RD);
  assign scan_all_valid = (st_q == ST_SCAN_ALL);
  assign slot_valid     = (st_q == ST_LATCH_DIF) && pick_any;
  assign slot_id        = pick_idx;

endmodule

// File: rtl/hp_poll_sched_chk.sv
module hp_poll_sched_chk #(
  parameter int LATCH_W    = 8,
  parameter int FIRST_SLOT = 1,
  parameter int LAST_SLOT  = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       tick,
  input logic                       latch_rd,
  input logic                       latch_vld,
  input logic                       scan_all_valid,
  input logic                       scan_all_ready,
  input logic                       slot_valid,
  input logic                       slot_ready,
  input logic [$clog2(LATCH_W)-1:0] slot_id
);

  a_r10_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({latch_rd, scan_all_valid, slot_valid}));

  a_r4_slot_hold: assert property (@(posedge clk) disable iff (rst)
    slot_valid && !slot_ready |=> slot_valid && $stable(slot_id));

  a_r3_slot_range: assert property (@(posedge clk) disable iff (rst)
    slot_valid |-> (int'(slot_id) >= FIRST_SLOT) && (int'(slot_id) <= LAST_SLOT));

  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    slot_valid && slot_ready |=> !slot_valid || (slot_id > $past(slot_id)));

  a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
    latch_rd && !latch_vld |=> latch_rd);

  a_r8_scan_hold: assert property (@(posedge clk) disable iff (rst)
    scan_all_valid && !scan_all_ready |=> scan_all_valid);

  a_r8_scan_then_latch: assert property (@(posedge clk) disable iff (rst)
    scan_all_valid && scan_all_ready |=> latch_rd && !scan_all_valid);

  a_r6_no_wake_without_tick: assert property (@(posedge clk) disable iff (rst)
    !latch_rd && !scan_all_valid && !slot_valid && !tick |=>
      !latch_rd && !scan_all_valid);

endmodule

bind hp_poll_sched hp_poll_sched_chk #(
  .LATCH_W    (LATCH_W),
  .FIRST_SLOT (FIRST_SLOT),
  .LAST_SLOT  (LAST_SLOT)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .tick           (tick),
  .latch_rd       (latch_rd),
  .latch_vld      (latch_vld),
  .scan_all_valid (scan_all_valid),
  .scan_all_ready (scan_all_ready),
  .slot_valid     (slot_valid),
  .slot_ready     (slot_ready),
  .slot_id        (slot_id)
);

// File: tb/hp_poll_sched_bench.sv
module hp_poll_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;
  localparam int NT = 4;      // sleep ticks, matches the default
  localparam int NV = 12;

  // {full pass expected, latch byte returned, expected reread mask}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00},
    {1'b0, 8'h06, 8'h06},
    {1'b0, 8'h87, 8'h00},
    {1'b0, 8'hF9, 8'h7E},
    {1'b0, 8'hF9, 8'h00},
    {1'b1, 8'h10, 8'h00},
    {1'b0, 8'h10, 8'h00},
    {1'b0, 8'h30, 8'h20},
    {1'b0, 8'h31, 8'h00},
    {1'b0, 8'h31, 8'h00},
    {1'b1, 8'h00, 8'h00},
    {1'b0, 8'h40, 8'h40}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic stop = 1'b0;
  logic latch_vld = 1'b0;
  logic [LW-1:0] latch_data = '0;
  logic scan_all_ready = 1'b0;
  logic slot_ready = 1'b0;
  logic latch_rd, scan_all_valid, slot_valid;
  logic [2:0] slot_id;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hp_poll_sched u_hp_poll_sched (
    .clk            (clk),
    .rst            (rst),
    .tick           (tick),
    .stop           (stop),
    .latch_rd       (latch_rd),
    .latch_vld      (latch_vld),
    .latch_data     (latch_data),
    .scan_all_valid (scan_all_valid),
    .scan_all_ready (scan_all_ready),
    .slot_valid     (slot_valid),
    .slot_ready     (slot_ready),
    .slot_id        (slot_id)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int reqs();
    return {29'd0, latch_rd, scan_all_valid, slot_valid};
  endfunction

  // count NT ticks; check silence before the last, then the wake result
  task automatic sleep_pass(input bit exp_full, input bit stop_end, input bit stop_early);
    @(negedge clk);
    for (int k = 0; k < NT; k++) begin
      if (stop_early && k == 0) stop = 1'b1;
      if (k == NT - 1) stop = stop_end;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (k < NT - 1) chk(reqs() == 0, "R6 quiet during sleep", reqs(), 0);
    end
    stop = 1'b0;
    if (stop_end)
      chk(reqs() == 0, "R9 halt at wake", reqs(), 0);
    else if (exp_full)
      chk(scan_all_valid && !latch_rd, "R7 full pass at wake", reqs(), 2);
    else
      chk(latch_rd && !scan_all_valid, "R7 latch pass at wake", reqs(), 4);
  endtask

  task automatic serve_latch(input logic [7:0] b, input logic [7:0] exp_mask);
    logic [7:0] got;
    int prev;
    bit first;
    logic [2:0] id;
    got = '0; prev = -1; first = 1'b1;
    @(negedge clk);
    chk(latch_rd == 1'b1, "R2 latch read held", latch_rd, 1);
    latch_vld = 1'b1; latch_data = b;
    @(negedge clk);
    latch_vld = 1'b0;
    for (int g = 0; g < 40; g++) begin
      if (!slot_valid) break;
      chk($onehot0(reqs()), "R10 single request", reqs(), 1);
      id = slot_id;
      chk(int'(id) > prev, "R3 ascending order", id, prev + 1);
      if (first) begin
        @(negedge clk);
        chk(slot_valid && slot_id == id, "R4 hold while not ready", slot_id, id);
        first = 1'b0;
      end
      slot_ready = 1'b1;
      @(negedge clk);
      slot_ready = 1'b0;
      got[id] = 1'b1;
      prev = int'(id);
    end
    if (exp_mask == 0)
      chk(got == exp_mask, "R5 no change no reread", got, exp_mask);
    else
      chk(got == exp_mask, "R3 reread set", got, exp_mask);
  endtask

  task automatic serve_full(input logic [7:0] b);
    @(negedge clk);
    chk(scan_all_valid && !latch_rd, "R8 scan-all held", reqs(), 2);
    scan_all_ready = 1'b1;
    @(negedge clk);
    scan_all_ready = 1'b0;
    chk(latch_rd && !scan_all_valid, "R8 latch refresh after scan", reqs(), 4);
    latch_vld = 1'b1; latch_data = b;
    @(negedge clk);
    latch_vld = 1'b0;
    chk(reqs() == 0, "R8 no reread after refresh", reqs(), 0);
    @(negedge clk);
    chk(!slot_valid, "R8 no reread after refresh", slot_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(latch_rd && !scan_all_valid && !slot_valid, "R1 reset outputs", reqs(), 4);
    rst = 1'b0;
    chk(latch_rd && !scan_all_valid && !slot_valid, "R1 first cycle", reqs(), 4);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) sleep_pass(VEC[i][16], 1'b0, 1'b0);
      if (VEC[i][16]) serve_full(VEC[i][15:8]);
      else            serve_latch(VEC[i][15:8], VEC[i][7:0]);
    end

    // R9: a stop that drops before the last tick is ignored
    sleep_pass(1'b0, 1'b0, 1'b1);
    serve_latch(8'h40, 8'h00);
    // R9: stop at the last tick halts for good
    sleep_pass(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 30; k++) begin
      tick = (k % 2 == 0);
      @(negedge clk);
      tick = 1'b0;
      chk(reqs() == 0, "R9 stays halted", reqs(), 0);
    end

    // R1: reset mid-run restores the latch pass and a zero stored byte
    rst = 1'b1;
    @(negedge clk);
    chk(latch_rd && !scan_all_valid && !slot_valid, "R1 reset outputs again", reqs(), 4);
    rst = 1'b0;
    serve_latch(8'h02, 8'h02);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule